// File: doc/BRIEF.md
# Asynchronous Host Memory Access Port

This block lets an external host read and write the chip's internal program memory (24-bit words) and data memory (16-bit words) over a 16-bit multiplexed address/data bus. The bus appears at the block edge as a separate inbound and outbound half. The host drives four strobes with no relation to the core clock: an address-latch strobe, an active-low select, and active-low read and write strobes. Each strobe passes through a two-flop synchronizer before the core clock domain looks for its edges.

A host transaction starts with an address phase. When the latch strobe falls, the port stores a 14-bit location and a one-bit memory-space flag. Data phases then access consecutive locations, and the port advances the address by itself. A program word needs two data transfers on the 16-bit bus. The internal side may also preload the address register.

The port can act as a boot source. When the boot-select pin is high and the map pin is low at reset, the `exec_hold` output stays asserted until a complete program word has been written to program location 0. Both internal memories are modelled as small synchronous RAMs.

Top module: `hmp_port`

## Requirements
- R1: During and after reset, `h_ack` is 1 and `h_rdata` is 0. The address register holds data-memory location 0, so a data transfer with no address phase accesses data location 0.
- R2: When the synchronized latch strobe falls, the port captures the inbound bus: bits [13:0] give the location, and bit 14 gives the space (1 = program memory, 0 = data memory). Bit 15 is ignored.
- R3: With select low, a write strobe low stores the 16-bit bus word in data memory at the current location. A read strobe low returns the stored word on `h_rdata`.
- R4: The location advances by one after every data-memory transfer and after every completed program word (its second transfer). It does not advance after a first program-word transfer.
- R5: A program word moves in two transfers. On write, the first transfer carries bits [23:8], and the second carries bits [7:0] in bus bits [7:0] and stores the word; bus bits [15:8] of the second transfer are ignored. On read, the first transfer returns bits [23:8] and the second returns {8'h00, bits [7:0]}.
- R6: For each data transfer, `h_ack` goes low for exactly two core cycles (one synchronization cycle and one access cycle) and is high at all other times.
- R7: `exec_hold` is 1 after reset only when `boot_sel`=1 and `map_sel`=0 during reset. It falls once a complete word is stored at program location 0, and no other write releases it. It never rises again outside reset.
- R8: A one-cycle `core_ld_en` pulse while the port is idle loads `core_ld_space` and `core_ld_loc` as the next transfer's location and space.
- R9: An address phase or a core preload discards a half-completed program word, so the next transfer is again a first transfer.
- R10: A read or write strobe with select high has no effect: `h_ack` stays high, memory is unchanged, and the location does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| h_latch | input | 1 | Host address-latch strobe, captured on its falling edge |
| h_sel_n | input | 1 | Host select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_wdata | input | 16 | Inbound half of the multiplexed bus (address or write data) |
| h_rdata | output | 16 | Outbound half of the multiplexed bus (read data) |
| h_ack | output | 1 | High when the port can accept the next phase |
| core_ld_en | input | 1 | Internal preload strobe for the address register |
| core_ld_space | input | 1 | Preload space: 1 program, 0 data |
| core_ld_loc | input | 14 | Preload location |
| boot_sel | input | 1 | Boot-mode pin, sampled during reset |
| map_sel | input | 1 | Memory-map pin, sampled during reset |
| exec_hold | output | 1 | Holds core execution while a port boot is pending |

## Verification
The main function is tried with three patterns:
- A burst of data-memory words written after one address phase and read back after a second one. This separates correct auto-increment from a stuck or double-stepping address.
- Two program words written as four half transfers with junk in the upper byte of each second half. Reading them back tells the upper and lower halves apart and shows whether the junk is masked.
- A relatch in the middle of a program word, followed by a core preload. These show whether the half-word phase is discarded and whether the preload address is honoured.

Strobes without select, writes to data location 0 and to program locations other than 0, and three boot-pin combinations separate the true release of `exec_hold` from false ones.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    localparam int HMP_LOC_W = 14;
    localparam int HMP_BUS_W = 16;
    localparam int HMP_PM_W  = 24;
    localparam int HMP_DM_W  = 16;
    localparam int HMP_LO_W  = HMP_PM_W - HMP_BUS_W;

    typedef enum logic {
        SPACE_DM = 1'b0,
        SPACE_PM = 1'b1
    } space_e;

    typedef struct packed {
        space_e               space;
        logic [HMP_LOC_W-1:0] loc;
    } hptr_t;

    typedef struct packed {
        logic                 wr;
        logic [HMP_BUS_W-1:0] data;
    } hreq_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_ACCESS = 2'd2
    } pst_e;

    function automatic hptr_t decode_ptr(input logic [HMP_BUS_W-1:0] bus);
        hptr_t p;
        p.space = space_e'(bus[HMP_LOC_W]);
        p.loc   = bus[HMP_LOC_W-1:0];
        return p;
    endfunction

    function automatic logic [HMP_BUS_W-1:0] pm_half(input logic [HMP_PM_W-1:0] w,
                                                     input logic low);
        if (low)
            return {{(HMP_BUS_W-HMP_LO_W){1'b0}}, w[HMP_LO_W-1:0]};
        return w[HMP_PM_W-1:HMP_LO_W];
    endfunction

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/hmp_ram.sv
module hmp_ram #(
    parameter int DW = 16,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
    import hmp_pkg::*;
#(
    parameter int LOC_W = HMP_LOC_W,
    parameter int BUS_W = HMP_BUS_W,
    parameter int PM_W  = HMP_PM_W,
    localparam int LO_W = PM_W - BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat_s,
    input  logic             sel_n_s,
    input  logic             rd_n_s,
    input  logic             wr_n_s,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             ld_en,
    input  hptr_t            ld_ptr,
    input  logic             boot_arm,
    input  logic [PM_W-1:0]  mem_rdata,
    output hptr_t            cur_ptr,
    output logic             mem_re,
    output logic             mem_we,
    output logic [PM_W-1:0]  mem_wdata,
    output logic             adv,
    output logic             ack,
    output logic [BUS_W-1:0] rdata,
    output logic             hold
);
    pst_e             st;
    hptr_t            ptr;
    hreq_t            req_r;
    logic             half;
    logic [BUS_W-1:0] stage;
    logic [BUS_W-1:0] rdata_q;
    logic             hold_q;
    logic             lat_d;
    logic             req_d;

    logic req_now;
    logic req_rise;
    logic lat_fall;
    logic is_pm;

    assign req_now  = ~sel_n_s & (~rd_n_s | ~wr_n_s);
    assign req_rise = req_now & ~req_d;
    assign lat_fall = ~lat_s & lat_d;
    assign is_pm    = (ptr.space == SPACE_PM);

    // one cycle to settle the request, one for the memory access
    assign mem_re = (st == ST_SYNC) & ~req_r.wr;
    assign mem_we = (st == ST_ACCESS) & req_r.wr & (~is_pm | half);
    assign mem_wdata = is_pm ? {stage, req_r.data[LO_W-1:0]}
                             : {{LO_W{1'b0}}, req_r.data};
    assign adv = (st == ST_ACCESS) & (~is_pm | half);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ptr     <= '{space: SPACE_DM, loc: '0};
            req_r   <= '0;
            half    <= 1'b0;
            stage   <= '0;
            rdata_q <= '0;
            hold_q  <= boot_arm;
            lat_d   <= 1'b0;
            req_d   <= 1'b0;
        end else begin
            lat_d <= lat_s;
            req_d <= req_now;
            unique case (st)
                ST_IDLE: begin
                    if (lat_fall) begin
                        ptr  <= decode_ptr(bus_in);
                        half <= 1'b0;
                    end else if (ld_en) begin
                        ptr  <= ld_ptr;
                        half <= 1'b0;
                    end
                    if (req_rise) begin
                        req_r <= '{wr: ~wr_n_s, data: bus_in};
                        st    <= ST_SYNC;
                    end
                end
                ST_SYNC: st <= ST_ACCESS;
                ST_ACCESS: begin
                    st <= ST_IDLE;
                    if (is_pm)
                        half <= ~half;
                    if (adv)
                        ptr.loc <= ptr.loc + 1'b1;
                    if (req_r.wr) begin
                        if (is_pm && !half)
                            stage <= req_r.data;
                        if (mem_we && is_pm && ptr.loc == '0)
                            hold_q <= 1'b0;
                    end else begin
                        rdata_q <= is_pm ? pm_half(mem_rdata, half)
                                         : mem_rdata[BUS_W-1:0];
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cur_ptr = ptr;
    assign ack     = (st == ST_IDLE);
    assign rdata   = rdata_q;
    assign hold    = hold_q;
endmodule

// File: rtl/hmp_port.sv
module hmp_port
    import hmp_pkg::*;
#(
    parameter int LOC_W  = HMP_LOC_W,
    parameter int BUS_W  = HMP_BUS_W,
    parameter int PM_W   = HMP_PM_W,
    parameter int MEM_AW = 8,
    localparam int DM_W  = BUS_W,
    localparam int PAD_W = PM_W - DM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_latch,
    input  logic             h_sel_n,
    input  logic             h_rd_n,
    input  logic             h_wr_n,
    input  logic [BUS_W-1:0] h_wdata,
    output logic [BUS_W-1:0] h_rdata,
    output logic             h_ack,
    input  logic             core_ld_en,
    input  logic             core_ld_space,
    input  logic [LOC_W-1:0] core_ld_loc,
    input  logic             boot_sel,
    input  logic             map_sel,
    output logic             exec_hold
);
    localparam int NSTB = 4;

    logic [NSTB-1:0] stb_s;
    hptr_t           cur_ptr;
    hptr_t           ld_ptr;
    logic            mem_re;
    logic            mem_we;
    logic [PM_W-1:0] mem_wdata;
    logic [PM_W-1:0] mem_rdata;
    logic [PM_W-1:0] pm_rdata;
    logic [DM_W-1:0] dm_rdata;
    logic            pm_we, dm_we, pm_re, dm_re;
    logic [LOC_W-1:0] cur_loc;
    logic            adv_w;

    hmp_sync #(.W(NSTB), .RST_VAL(4'b0111)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({h_latch, h_sel_n, h_rd_n, h_wr_n}),
        .q_sync  (stb_s)
    );

    assign ld_ptr = '{space: space_e'(core_ld_space), loc: core_ld_loc};

    hmp_ctrl #(.LOC_W(LOC_W), .BUS_W(BUS_W), .PM_W(PM_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .lat_s     (stb_s[3]),
        .sel_n_s   (stb_s[2]),
        .rd_n_s    (stb_s[1]),
        .wr_n_s    (stb_s[0]),
        .bus_in    (h_wdata),
        .ld_en     (core_ld_en),
        .ld_ptr    (ld_ptr),
        .boot_arm  (boot_sel & ~map_sel),
        .mem_rdata (mem_rdata),
        .cur_ptr   (cur_ptr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .adv       (adv_w),
        .ack       (h_ack),
        .rdata     (h_rdata),
        .hold      (exec_hold)
    );

    assign cur_loc = cur_ptr.loc;
    assign pm_we = mem_we & (cur_ptr.space == SPACE_PM);
    assign dm_we = mem_we & (cur_ptr.space == SPACE_DM);
    assign pm_re = mem_re & (cur_ptr.space == SPACE_PM);
    assign dm_re = mem_re & (cur_ptr.space == SPACE_DM);

    hmp_ram #(.DW(PM_W), .AW(MEM_AW)) u_pm (
        .clk   (clk),
        .re    (pm_re),
        .we    (pm_we),
        .addr  (cur_ptr.loc[MEM_AW-1:0]),
        .wdata (mem_wdata),
        .rdata (pm_rdata)
    );

    hmp_ram #(.DW(DM_W), .AW(MEM_AW)) u_dm (
        .clk   (clk),
        .re    (dm_re),
        .we    (dm_we),
        .addr  (cur_ptr.loc[MEM_AW-1:0]),
        .wdata (mem_wdata[DM_W-1:0]),
        .rdata (dm_rdata)
    );

    assign mem_rdata = (cur_ptr.space == SPACE_PM) ? pm_rdata : {{PAD_W{1'b0}}, dm_rdata};
endmodule

// File: rtl/hmp_port_chk.sv
module hmp_port_chk #(
    parameter int LOC_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             h_ack,
    input logic             exec_hold,
    input logic             pm_we,
    input logic             dm_we,
    input logic [LOC_W-1:0] cur_loc,
    input logic             adv_w
);
    // R6: every busy window is exactly two cycles
    p_ack_window_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(h_ack) |=> !h_ack ##1 h_ack);

    // R3: memory is written only inside a busy window
    p_we_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (pm_we || dm_we) |-> !h_ack);

    // R3: never both memories in one cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pm_we, dm_we}));

    // R4: a completed transfer steps the location by one
    p_advance_r4: assert property (@(posedge clk) disable iff (rst)
        adv_w |=> cur_loc == $past(cur_loc) + 1'b1);

    // R7: the hold is never re-armed outside reset
    p_hold_norise_r7: assert property (@(posedge clk) disable iff (rst)
        !$rose(exec_hold));

    // R7: release follows a program write to location 0
    p_hold_release_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(exec_hold) |-> $past(pm_we && cur_loc == '0));
endmodule

bind hmp_port hmp_port_chk #(.LOC_W(LOC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .h_ack     (h_ack),
    .exec_hold (exec_hold),
    .pm_we     (pm_we),
    .dm_we     (dm_we),
    .cur_loc   (cur_loc),
    .adv_w     (adv_w)
);

// File: tb/hmp_port_bench.sv
module hmp_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_latch = 1'b0;
    logic        h_sel_n = 1'b1;
    logic        h_rd_n = 1'b1;
    logic        h_wr_n = 1'b1;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        h_ack;
    logic        core_ld_en = 1'b0;
    logic        core_ld_space = 1'b0;
    logic [13:0] core_ld_loc = '0;
    logic        boot_sel = 1'b1;
    logic        map_sel = 1'b0;
    logic        exec_hold;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] rd_obs;
    event        rd_evt;

    always #5 clk = ~clk;

    hmp_port u_hmp_port (
        .clk(clk), .rst(rst), .h_latch(h_latch), .h_sel_n(h_sel_n),
        .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_ack(h_ack), .core_ld_en(core_ld_en), .core_ld_space(core_ld_space),
        .core_ld_loc(core_ld_loc), .boot_sel(boot_sel), .map_sel(map_sel),
        .exec_hold(exec_hold)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(rd_evt);
            if (exp_q.size() == 0) begin
                chk("R3 unexpected read", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), {16'h0, rd_obs}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic do_reset(input logic bs, input logic ms);
        @(negedge clk);
        rst = 1'b1; boot_sel = bs; map_sel = ms;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic addr_phase(input logic [15:0] word);
        @(negedge clk);
        h_wdata = word; h_latch = 1'b1;
        repeat (3) @(negedge clk);
        h_latch = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic xfer(input logic wr, input logic [15:0] d, output logic [15:0] q);
        int wait_n = 0;
        int low_n = 0;
        @(negedge clk);
        h_wdata = d; h_sel_n = 1'b0;
        if (wr) h_wr_n = 1'b0; else h_rd_n = 1'b0;
        while (h_ack && wait_n < 10) begin
            @(negedge clk);
            wait_n++;
        end
        while (!h_ack && low_n < 10) begin
            @(negedge clk);
            low_n++;
        end
        chk("R6 ack low cycles", low_n, 2);
        q = h_rdata;
        h_sel_n = 1'b1; h_rd_n = 1'b1; h_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic hwrite(input logic [15:0] d);
        logic [15:0] dummy;
        xfer(1'b1, d, dummy);
    endtask

    task automatic hread(input string tag, input logic [15:0] exp);
        logic [15:0] q;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        xfer(1'b0, 16'h0, q);
        rd_obs = q;
        ->rd_evt;
    endtask

    task automatic preload(input logic sp, input logic [13:0] loc);
        @(negedge clk);
        core_ld_en = 1'b1; core_ld_space = sp; core_ld_loc = loc;
        @(negedge clk);
        core_ld_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset(1'b1, 1'b0);
        chk("R1 ack after reset", h_ack, 1);
        chk("R1 rdata after reset", h_rdata, 0);
        chk("R7 hold armed", exec_hold, 1);

        // R2 R3 R4: data burst, bit 15 of the relatch word is junk
        addr_phase(16'h0010);
        hwrite(16'hA0A1); hwrite(16'hB0B1); hwrite(16'hC0C1);
        addr_phase(16'h8010);
        hread("R3 dm word0", 16'hA0A1);
        hread("R4 dm word1", 16'hB0B1);
        hread("R4 dm word2", 16'hC0C1);

        // R5: two program words, junk in upper byte of low halves
        addr_phase(16'h4005);
        hwrite(16'h1234); hwrite(16'hFF56);
        hwrite(16'hABCD); hwrite(16'h77EF);
        addr_phase(16'h4005);
        hread("R5 pm5 high", 16'h1234);
        hread("R5 pm5 low", 16'h0056);
        hread("R5 pm6 high", 16'hABCD);
        hread("R5 pm6 low", 16'h00EF);
        chk("R7 hold after pm5 write", exec_hold, 1);

        addr_phase(16'h0000);
        hwrite(16'h0D0D);
        chk("R7 hold after dm0 write", exec_hold, 1);

        // R9: abandoned half word at program location 0
        addr_phase(16'h4000);
        hwrite(16'h1111);
        chk("R7 hold after half word", exec_hold, 1);
        addr_phase(16'h4000);
        hwrite(16'h2222); hwrite(16'h0033);
        chk("R7 hold released", exec_hold, 0);
        addr_phase(16'h4000);
        hread("R9 pm0 high", 16'h2222);
        hread("R9 pm0 low", 16'h0033);

        // R8: core preload
        preload(1'b0, 14'h0011);
        hread("R8 dm preload", 16'hB0B1);
        preload(1'b1, 14'h0006);
        hread("R8 pm preload high", 16'hABCD);
        hread("R8 pm preload low", 16'h00EF);

        // R10: strobes without select
        addr_phase(16'h0020);
        hwrite(16'h5555);
        addr_phase(16'h0020);
        @(negedge clk);
        h_wdata = 16'h9999; h_wr_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10 ack stays high", h_ack, 1);
        end
        h_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        hread("R10 no write no step", 16'h5555);

        // R7/R1: other boot pin settings, reset location
        do_reset(1'b0, 1'b0);
        chk("R7 no hold boot0 map0", exec_hold, 0);
        hread("R1 reset location dm0", 16'h0D0D);
        do_reset(1'b1, 1'b1);
        chk("R7 no hold boot1 map1", exec_hold, 0);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule